// File: doc/BRIEF.md
# Two-Set GPIO Blink Generator

This block drives the pad output word of a 32-line GPIO bank. It keeps two shared timing sets, A and B. Each set has a programmable high time and low time, both counted in clock cycles, and produces one square-wave phase signal from them. Every line carries a set-select bit that ties it to one of the two phases. A line in output mode whose blink-enable bit is set drives that phase onto its pad. Any other output line drives the value of its output latch.

Lines marked as inputs drive zero and keep their output enable low. New durations take effect only at the next phase boundary, so a running waveform is never cut short in the middle of a phase. Converting cycle counts into time units is left to the software that programs the counts.

Top module: `gpio_blink_gen`

## Requirements
- R1: A write with `wr_en_i` high loads `wr_data_i` into one duration register. `wr_set_i` picks the set (0 = A, 1 = B). `wr_addr_i` picks the register: byte offset 0x0 is the high (on) count and 0x4 is the low (off) count.
- R2: With both counts of a set non-zero, the set's phase is high for exactly `on` cycles and then low for exactly `off` cycles, and repeats. The period is `on + off` cycles.
- R3: A line whose select bit is 0 follows set A. A line whose select bit is 1 follows set B.
- R4: An output line (direction bit 0) with blink-enable 1 drives its set's phase on `pad_o`. With blink-enable 0 it drives its `out_latch_i` bit.
- R5: `pad_o` and `pad_oe_o` are registered. Clearing a blink-enable bit makes the pad show the latch value on the first clock edge after the change.
- R6: An active on count of zero holds the set's phase low continuously.
- R7: An active off count of zero with a non-zero on count holds the set's phase high continuously.
- R8: Duration registers written during a running phase are adopted only at the next phase boundary. The current phase completes with its old length.
- R9: A line with direction bit 1 (input) drives 0 on `pad_o` and 0 on `pad_oe_o`, whatever its blink, select and latch bits are. Output lines drive `pad_oe_o` high.
- R10: After reset, `pad_o` and `pad_oe_o` are zero and all four duration registers are zero, so both phases stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Duration register write strobe |
| wr_set_i | input | 1 | Timing set for the write (0 = A, 1 = B) |
| wr_addr_i | input | 3 | Byte offset: 0x0 on count, 0x4 off count |
| wr_data_i | input | 32 | Duration value in clock cycles |
| out_latch_i | input | 32 | Per-line output latch value |
| blink_en_i | input | 32 | Per-line blink enable |
| cnt_sel_i | input | 32 | Per-line timing set select |
| dir_in_i | input | 32 | Per-line direction, 1 = input |
| pad_o | output | 32 | Registered pad output value |
| pad_oe_o | output | 32 | Registered pad output enable |

## Verification
A table of static vectors mixes direction, blink, select and latch words. During this table set A is held low (on count zero) and set B is held high (off count zero). A line that wrongly picks the latch, the other set, or a driven value while in input mode therefore shows up as a flipped bit. Live waveforms are then measured edge to edge on lines bound to different sets, and measured again with the selects swapped, which separates the two counters. A mid-phase rewrite of the on count shows whether the new value lands at the boundary or truncates the current phase. The degenerate counts and blink clearing are each checked on their own.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;
  localparam int unsigned NUM_SETS = 2;
  localparam int unsigned SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int unsigned ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] ADDR_ON  = 3'h0;
  localparam logic [ADDR_W-1:0] ADDR_OFF = 3'h4;
endpackage

// File: rtl/gpio_blink_regs.sv
module gpio_blink_regs
  import gpio_blink_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [SET_W-1:0]                wr_set_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [CNT_W-1:0]                wr_data_i,
  output logic [NUM_SETS-1:0][CNT_W-1:0]  on_cfg_o,
  output logic [NUM_SETS-1:0][CNT_W-1:0]  off_cfg_o
);
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic hit;
    assign hit = wr_en_i && (wr_set_i == SET_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        on_cfg_o[s]  <= '0;
        off_cfg_o[s] <= '0;
      end else if (hit) begin
        if (wr_addr_i == ADDR_ON)  on_cfg_o[s]  <= wr_data_i;
        if (wr_addr_i == ADDR_OFF) off_cfg_o[s] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] on_cfg_i,
  input  logic [CNT_W-1:0] off_cfg_i,
  output logic             phase_o
);
  logic [CNT_W-1:0] act_on_q, act_off_q, cnt_q, cur_dur;
  logic             phase_q, degen, at_end, phase_nxt;

  // a degenerate set re-samples its durations every cycle
  assign degen   = (act_on_q == '0) || (act_off_q == '0);
  assign cur_dur = phase_q ? act_on_q : act_off_q;
  assign at_end  = degen || (cnt_q == cur_dur - CNT_W'(1));

  always_comb begin
    if (on_cfg_i == '0)       phase_nxt = 1'b0;
    else if (off_cfg_i == '0) phase_nxt = 1'b1;
    else if (degen)           phase_nxt = 1'b1;
    else                      phase_nxt = ~phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_on_q  <= '0;
      act_off_q <= '0;
      cnt_q     <= '0;
      phase_q   <= 1'b0;
    end else if (at_end) begin
      act_on_q  <= on_cfg_i;
      act_off_q <= off_cfg_i;
      cnt_q     <= '0;
      phase_q   <= phase_nxt;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/gpio_blink_line_mux.sv
module gpio_blink_line_mux
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SETS-1:0]  phase_i,
  input  logic [NUM_LINES-1:0] out_latch_i,
  input  logic [NUM_LINES-1:0] blink_en_i,
  input  logic [NUM_LINES-1:0] cnt_sel_i,
  input  logic [NUM_LINES-1:0] dir_in_i,
  output logic [NUM_LINES-1:0] pad_o,
  output logic [NUM_LINES-1:0] pad_oe_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic val;
    always_comb begin
      if (dir_in_i[i])        val = 1'b0;
      else if (blink_en_i[i]) val = phase_i[cnt_sel_i[i]];
      else                    val = out_latch_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pad_o[i]    <= 1'b0;
        pad_oe_o[i] <= 1'b0;
      end else begin
        pad_o[i]    <= val;
        pad_oe_o[i] <= ~dir_in_i[i];
      end
    end
  end
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned CNT_W     = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [SET_W-1:0]     wr_set_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  input  logic [NUM_LINES-1:0] out_latch_i,
  input  logic [NUM_LINES-1:0] blink_en_i,
  input  logic [NUM_LINES-1:0] cnt_sel_i,
  input  logic [NUM_LINES-1:0] dir_in_i,
  output logic [NUM_LINES-1:0] pad_o,
  output logic [NUM_LINES-1:0] pad_oe_o
);
  logic [NUM_SETS-1:0][CNT_W-1:0] on_cfg, off_cfg;
  logic [NUM_SETS-1:0]            phase;

  gpio_blink_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_set_i, .wr_addr_i, .wr_data_i,
    .on_cfg_o (on_cfg),
    .off_cfg_o(off_cfg)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_timer
    gpio_blink_timer #(.CNT_W(CNT_W)) i_timer (
      .clk_i, .rst_ni,
      .on_cfg_i (on_cfg[s]),
      .off_cfg_i(off_cfg[s]),
      .phase_o  (phase[s])
    );
  end

  gpio_blink_line_mux #(.NUM_LINES(NUM_LINES)) i_mux (
    .clk_i, .rst_ni,
    .phase_i(phase),
    .out_latch_i, .blink_en_i, .cnt_sel_i, .dir_in_i,
    .pad_o, .pad_oe_o
  );
endmodule

// File: rtl/gpio_blink_chk.sv
module gpio_blink_chk
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_SETS-1:0]  phase_i,
  input logic [NUM_LINES-1:0] out_latch_i,
  input logic [NUM_LINES-1:0] blink_en_i,
  input logic [NUM_LINES-1:0] cnt_sel_i,
  input logic [NUM_LINES-1:0] dir_in_i,
  input logic [NUM_LINES-1:0] pad_o,
  input logic [NUM_LINES-1:0] pad_oe_o
);
  logic                 past_ok;
  logic [NUM_LINES-1:0] sel_ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) sel_ph[i] = phase_i[cnt_sel_i[i]];
  end

  // R9
  in_line_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((pad_o & $past(dir_in_i)) == '0));

  // R9
  oe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (pad_oe_o == ~$past(dir_in_i)));

  // R5
  latch_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (((pad_o ^ $past(out_latch_i)) & $past(~dir_in_i & ~blink_en_i)) == '0));

  // R4
  blink_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (((pad_o ^ $past(sel_ph)) & $past(~dir_in_i & blink_en_i)) == '0));
endmodule

bind gpio_blink_gen gpio_blink_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase),
  .out_latch_i(out_latch_i), .blink_en_i(blink_en_i), .cnt_sel_i(cnt_sel_i),
  .dir_in_i(dir_in_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o)
);

// File: tb/test_gpio_blink_gen.sv
module test_gpio_blink_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_set = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] latch = '0, blink = '0, sel = '0, dir = '0;
  logic [31:0] pad, oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_blink_gen i_gpio_blink_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_set_i(wr_set),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .out_latch_i(latch),
    .blink_en_i(blink), .cnt_sel_i(sel), .dir_in_i(dir),
    .pad_o(pad), .pad_oe_o(oe)
  );

  // {dir, blink, sel, latch, exp_pad, exp_oe}; set A held low, set B held high
  localparam logic [191:0] VEC [8] = '{
    {32'h0, 32'h0, 32'h0, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'hFFFFFFFF},
    {32'h0, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'h0, 32'h0F0F0F0F, 32'hFFFFFFFF},
    {32'h0, 32'hFFFF0000, 32'h00FF00FF, 32'h12345678, 32'h00FF5678, 32'hFFFFFFFF},
    {32'hFFFF0000, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0000FFFF, 32'h0000FFFF},
    {32'hF0F0F0F0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0F0F0F0F, 32'h0F0F0F0F},
    {32'h0, 32'h0000FFFF, 32'hFFFFFFFF, 32'hAAAA0000, 32'hAAAAFFFF, 32'hFFFFFFFF},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0},
    {32'h0, 32'h80000001, 32'h00000001, 32'h7FFFFFFE, 32'h7FFFFFFF, 32'hFFFFFFFF}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit set, logic [2:0] addr, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_set = set; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(int idx, output int hi, output int lo);
    int n;
    hi = 0; lo = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (pad[idx] !== 1'b0 && n < 200);
    n = 0;
    do begin @(negedge clk); n++; end while (pad[idx] !== 1'b1 && n < 200);
    while (pad[idx] === 1'b1 && hi < 200) begin hi++; @(negedge clk); end
    while (pad[idx] === 1'b0 && lo < 200) begin lo++; @(negedge clk); end
  endtask

  initial begin
    int hi, lo, cnt;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 pad in reset", pad, 32'h0);
    chk("R10 oe in reset", oe, 32'h0);
    rst_n = 1'b1;
    blink = 32'hFFFFFFFF; latch = 32'hFFFFFFFF;
    repeat (5) @(negedge clk);
    chk("R10 zero durations keep phase low", pad, 32'h0);

    // table: A on=0 (low), B on=5 off=0 (high)
    wr(1'b1, 3'h0, 32'd5);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      dir = VEC[i][191:160]; blink = VEC[i][159:128];
      sel = VEC[i][127:96];  latch = VEC[i][95:64];
      @(negedge clk);
      chk($sformatf("R3/R4/R9 vec%0d pad", i), pad, VEC[i][63:32]);
      chk($sformatf("R9 vec%0d oe", i), oe, VEC[i][31:0]);
    end

    // R1 R2: live waveforms, line0 on A, line1 on B
    dir = '0; latch = '0; blink = 32'h3; sel = 32'h2;
    wr(1'b0, 3'h0, 32'd3); wr(1'b0, 3'h4, 32'd5);
    wr(1'b1, 3'h0, 32'd7); wr(1'b1, 3'h4, 32'd2);
    repeat (30) @(negedge clk);
    measure(0, hi, lo);
    chk("R2 set A high", hi, 3); chk("R2 set A low", lo, 5);
    chk("R2 set A period", hi + lo, 8);
    measure(1, hi, lo);
    chk("R1 set B high", hi, 7); chk("R1 set B low", lo, 2);
    // R3: swap selects
    sel = 32'h1;
    measure(0, hi, lo);
    chk("R3 line0 on B high", hi, 7); chk("R3 line0 on B low", lo, 2);
    measure(1, hi, lo);
    chk("R3 line1 on A high", hi, 3); chk("R3 line1 on A low", lo, 5);

    // R8: rewrite on count during a high phase of set A
    sel = 32'h2;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (pad[0] !== 1'b0 && cnt < 200);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (pad[0] !== 1'b1 && cnt < 200);
    wr_en = 1'b1; wr_set = 1'b0; wr_addr = 3'h0; wr_data = 32'd6;
    hi = 1;
    @(negedge clk); wr_en = 1'b0;
    while (pad[0] === 1'b1 && hi < 200) begin hi++; @(negedge clk); end
    lo = 0;
    while (pad[0] === 1'b0 && lo < 200) begin lo++; @(negedge clk); end
    chk("R8 current high keeps old length", hi, 3);
    chk("R8 low unchanged", lo, 5);
    hi = 0;
    while (pad[0] === 1'b1 && hi < 200) begin hi++; @(negedge clk); end
    chk("R8 next high uses new count", hi, 6);

    // R6: on=0 -> low continuously
    wr(1'b0, 3'h0, 32'd0);
    repeat (20) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (pad[0]) cnt++; end
    chk("R6 on zero stays low", cnt, 0);

    // R7: off=0, on=4 -> high continuously
    wr(1'b0, 3'h0, 32'd4); wr(1'b0, 3'h4, 32'd0);
    repeat (20) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (pad[0]) cnt++; end
    chk("R7 off zero stays high", cnt, 16);

    // R5: clearing blink shows latch after one edge
    latch = 32'h0; blink = 32'h1; sel = 32'h0;
    @(negedge clk);
    chk("R4 blinking line follows high set", pad[0], 1'b1);
    blink = 32'h0;
    @(negedge clk);
    chk("R5 blink cleared shows latch", pad[0], 1'b0);
    blink = 32'h1;
    @(negedge clk);
    chk("R4 blink re-enabled", pad[0], 1'b1);

    // R9: input line with everything set stays quiet
    dir = 32'h1; latch = 32'h1;
    @(negedge clk);
    chk("R9 input line pad", pad[0], 1'b0);
    chk("R9 input line oe", oe[0], 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule